// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block chooses which pending interrupt is handed to a small 8-bit CPU core. It also gives the core the running priority level to load when that interrupt is entered. There are three classes of source. The first is reset. The second is the non-maskable class, made of an external non-maskable line and the software trap strobe. The third is a parameterised set of maskable peripheral sources. Each maskable source has a 2-bit software priority. That priority is compared with the 2-bit running level the core holds in its condition-code bits.

A peripheral request is raised only when its status flag and its enable bit are both high. A raised request sets a per-source pending latch. A maskable source is accepted only when it is enabled and its priority is strictly above the running level. A request that is refused stays latched. A clear strobe discards it silently. When a non-maskable source is entered, the new level is forced to 3. When a maskable source is entered, the new level takes that source's priority. The running level is echoed back so that the core can stack it.

The offer to the core is a valid/ready pair.
- The vector index, new level and previous level are meaningful while `irq_valid` is high.
- A transfer happens on a clock edge where `irq_valid` and `irq_ready` are both high. That transfer clears the chosen source's latch.
- While ready is low, nothing is cleared and valid stays high.
- The offered vector may be replaced by a higher-ranked arrival before the transfer. Valid can drop only if the core changes the running level or an enable, or if the offered maskable latch is cleared.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset is released, a reset entry is offered first. It uses vector 0 and new level 3. Taking it removes it, and it is never offered again until the next reset.
- R2: A trap strobe is latched. It is offered as vector 1 with new level 3, even when the running level is 3.
- R3: A non-maskable request is offered as vector 2 with new level 3, whatever the running level. The ranking is fixed: reset first, then trap, then non-maskable, then any maskable source.
- R4: A maskable source i (vector 3+i) is offered only while its enable is high and its 2-bit priority is strictly greater than the running level. An equal priority is refused.
- R5: A maskable request that is refused stays pending. It is offered once the blocking condition goes away.
- R6: A clear strobe on a source drops its pending latch in the next cycle. A request dropped this way is never offered.
- R7: A source's pending latch is set only in a cycle where its flag and its enable are both high. A flag seen while the enable is low leaves nothing pending.
- R8: Among eligible maskable sources, the higher priority wins. When priorities are equal, the lowest-numbered source wins.
- R9: On a maskable offer, the new level equals the source's priority and the previous level equals the running level. A transfer clears that source's latch.
- R10: The wake output is high in the cycle after a trap or non-maskable request. It stays high while such a request is pending, and it is low after reset.
- R11: While valid is high and ready is low, valid stays high and no pending source is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag | input | N_SRC | Peripheral status flags |
| src_en | input | N_SRC | Per-source enable bits |
| src_prio | input | 2*N_SRC | Software priority, source i in bits [2i+1:2i] |
| src_clr | input | N_SRC | Clear strobes that drop a pending latch |
| trap_req | input | 1 | Software trap strobe |
| nmi_req | input | 1 | External non-maskable request |
| cur_lvl | input | 2 | Running level from the condition-code bits |
| irq_ready | input | 1 | Core takes the offered entry |
| irq_valid | output | 1 | An entry is offered |
| irq_vector | output | VEC_W | Vector index: 0 reset, 1 trap, 2 non-maskable, 3+i source i |
| irq_new_lvl | output | 2 | Level to load on entry |
| irq_prev_lvl | output | 2 | Running level to stack |
| wake | output | 1 | Release from halt |

## Verification
Several things can fall in one cycle: a trap strobe, a non-maskable request and an eligible maskable request. All three are raised on the same edge, and the bench then takes the offers one by one. It checks that they come out in the order trap, non-maskable, maskable, and that each new level is correct. Tie-break and priority ordering are tested the same way. Three maskable sources are pulsed on one edge, and the bench checks the order in which they are drained.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_TOP  = 2'd3;
  localparam int   VEC_RST  = 0;
  localparam int   VEC_TRAP = 1;
  localparam int   VEC_NMI  = 2;
  localparam int   VEC_BASE = 3;
endpackage

// File: rtl/nic_pend_bank.sv
module nic_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] take_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[i] <= 1'b0;
      else        pend_o[i] <= (set_i[i] | (pend_o[i] & ~take_i[i])) & ~clr_i[i];
    end

    assert_clr_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[i] |=> !pend_o[i]);
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     elig_i,
  input  logic [2*N-1:0]   prio_i,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic [1:0]       win_prio_o
);
  always_comb begin
    win_vld_o  = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i] && (!win_vld_o || prio_i[2*i +: 2] >= win_prio_o)) begin
        win_vld_o  = 1'b1;
        win_idx_o  = IDX_W'(i);
        win_prio_o = prio_i[2*i +: 2];
      end
    end
  end

  assert_win_elig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> elig_i[win_idx_o]);
  assert_win_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_i != '0) |-> win_vld_o);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int VEC_W = $clog2(N_SRC + VEC_BASE),
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_flag,
  input  logic [N_SRC-1:0]   src_en,
  input  logic [2*N_SRC-1:0] src_prio,
  input  logic [N_SRC-1:0]   src_clr,
  input  logic               trap_req,
  input  logic               nmi_req,
  input  logic [1:0]         cur_lvl,
  input  logic               irq_ready,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vector,
  output logic [1:0]         irq_new_lvl,
  output logic [1:0]         irq_prev_lvl,
  output logic               wake
);
  logic             rst_pend;
  logic [1:0]       nm_pend;   // [1] trap, [0] non-maskable line
  logic [1:0]       nm_take;
  logic [N_SRC-1:0] m_pend, m_take, elig;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]       win_prio;
  logic             take, mask_sel;

  nic_pend_bank #(.N(N_SRC)) u_mbank (
    .clk(clk), .rst_n(rst_n), .set_i(src_flag & src_en),
    .take_i(m_take), .clr_i(src_clr), .pend_o(m_pend));

  nic_pend_bank #(.N(2)) u_nbank (
    .clk(clk), .rst_n(rst_n), .set_i({trap_req, nmi_req}),
    .take_i(nm_take), .clr_i(2'b00), .pend_o(nm_pend));

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = m_pend[i] & src_en[i] & (src_prio[2*i +: 2] > cur_lvl);
  end

  nic_arbiter #(.N(N_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig_i(elig), .prio_i(src_prio),
    .win_vld_o(win_vld), .win_idx_o(win_idx), .win_prio_o(win_prio));

  always_comb begin
    irq_valid   = 1'b1;
    mask_sel    = 1'b0;
    irq_new_lvl = LVL_TOP;
    if (rst_pend)        irq_vector = VEC_W'(VEC_RST);
    else if (nm_pend[1]) irq_vector = VEC_W'(VEC_TRAP);
    else if (nm_pend[0]) irq_vector = VEC_W'(VEC_NMI);
    else begin
      irq_vector  = VEC_W'(win_idx) + VEC_W'(VEC_BASE);
      irq_new_lvl = win_prio;
      mask_sel    = win_vld;
      irq_valid   = win_vld;
    end
  end

  assign irq_prev_lvl = cur_lvl;
  assign take    = irq_valid & irq_ready;
  assign nm_take = {take & ~rst_pend & nm_pend[1],
                    take & ~rst_pend & ~nm_pend[1] & nm_pend[0]};
  assign m_take  = (take && mask_sel) ? (N_SRC'(1) << win_idx) : '0;
  assign wake    = |nm_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rst_pend <= 1'b1;
    else if (take) rst_pend <= 1'b0;
  end

  logic [IDX_W-1:0] vec_src;
  assign vec_src = IDX_W'(irq_vector - VEC_W'(VEC_BASE));

  assert_reset_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |-> (irq_valid && irq_vector == VEC_W'(VEC_RST)));
  assert_nm_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vector < VEC_W'(VEC_BASE)) |-> irq_new_lvl == LVL_TOP);
  assert_mask_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vector >= VEC_W'(VEC_BASE)) |->
      (src_en[vec_src] && src_prio[{vec_src, 1'b0} +: 2] > cur_lvl));
  assert_trap_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> wake);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && src_clr == '0) |=>
      (irq_valid || !$stable(cur_lvl) || !$stable(src_en)));
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_flag = '0, src_en = '0, src_clr = '0;
  logic [2*N-1:0] src_prio = '0;
  logic trap_req = 1'b0, nmi_req = 1'b0, irq_ready = 1'b0;
  logic [1:0] cur_lvl = 2'd0;
  logic irq_valid, wake;
  logic [3:0] irq_vector;
  logic [1:0] irq_new_lvl, irq_prev_lvl;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  nest_irq_ctrl #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
    .src_prio(src_prio), .src_clr(src_clr), .trap_req(trap_req),
    .nmi_req(nmi_req), .cur_lvl(cur_lvl), .irq_ready(irq_ready),
    .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_new_lvl(irq_new_lvl), .irq_prev_lvl(irq_prev_lvl), .wake(wake));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic accept();
    tick(); irq_ready = 1'b1;
    tick(); irq_ready = 1'b0; #1;
  endtask

  task automatic set_prio(input int i, input int p);
    src_prio[2*i +: 2] = 2'(p);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    rst_n = 1'b1; #1;
    check("R1 reset offer valid", irq_valid, 1);
    check("R1 reset vector", irq_vector, 0);
    check("R1 reset new level", irq_new_lvl, 3);
    check("R10 wake low after reset", wake, 0);
    repeat (3) tick();
    #1 check("R11 held while not ready", irq_valid, 1);
    check("R11 vector held", irq_vector, 0);
    accept();
    check("R1 reset taken once", irq_valid, 0);
  endtask

  task automatic t_mask_basic();
    cur_lvl = 2'd1; set_prio(3, 2); src_en[3] = 1'b1;
    tick(); src_flag[3] = 1'b1;
    tick(); src_flag[3] = 1'b0; #1;
    check("R9 vector src3", irq_vector, 6);
    check("R9 new level", irq_new_lvl, 2);
    check("R9 prev level", irq_prev_lvl, 1);
    accept();
    check("R9 latch cleared on take", irq_valid, 0);
    src_en[3] = 1'b0;
  endtask

  task automatic t_strict();
    cur_lvl = 2'd2; set_prio(1, 2); src_en[1] = 1'b1;
    tick(); src_flag[1] = 1'b1;
    tick(); src_flag[1] = 1'b0; #1;
    check("R4 equal priority refused", irq_valid, 0);
    tick(); cur_lvl = 2'd1; #1;
    check("R5 pending offered later", irq_valid, 1);
    check("R5 vector src1", irq_vector, 4);
    accept();
    src_en[1] = 1'b0;
  endtask

  task automatic t_enable();
    cur_lvl = 2'd0; set_prio(2, 3); src_en[2] = 1'b1;
    tick(); src_flag[2] = 1'b1;
    tick(); src_flag[2] = 1'b0; src_en[2] = 1'b0; #1;
    check("R4 disabled not offered", irq_valid, 0);
    tick(); src_en[2] = 1'b1; #1;
    check("R5 re-enabled offered", irq_vector, 5);
    check("R5 re-enabled valid", irq_valid, 1);
    accept();
    src_en[2] = 1'b0;
  endtask

  task automatic t_gate();
    set_prio(4, 3);
    tick(); src_flag[4] = 1'b1;
    tick(); src_flag[4] = 1'b0; src_en[4] = 1'b1;
    tick(); #1;
    check("R7 flag without enable not latched", irq_valid, 0);
    src_en[4] = 1'b0;
  endtask

  task automatic t_clear();
    cur_lvl = 2'd3; set_prio(5, 3); src_en[5] = 1'b1;
    tick(); src_flag[5] = 1'b1;
    tick(); src_flag[5] = 1'b0; #1;
    check("R4 level 3 blocks maskable", irq_valid, 0);
    src_clr[5] = 1'b1;
    tick(); src_clr[5] = 1'b0; cur_lvl = 2'd0; #1;
    check("R6 cleared request dropped", irq_valid, 0);
    src_en[5] = 1'b0;
  endtask

  task automatic t_tie();
    cur_lvl = 2'd0;
    set_prio(2, 1); set_prio(6, 1); set_prio(7, 2);
    src_en[2] = 1'b1; src_en[6] = 1'b1; src_en[7] = 1'b1;
    tick(); src_flag[2] = 1'b1; src_flag[6] = 1'b1; src_flag[7] = 1'b1;
    tick(); src_flag = '0; #1;
    check("R8 higher priority first", irq_vector, 10);
    accept();
    check("R8 tie lowest index", irq_vector, 5);
    check("R9 tie new level", irq_new_lvl, 1);
    accept();
    check("R8 last of tie", irq_vector, 9);
    accept();
    check("R8 all drained", irq_valid, 0);
    src_en = '0;
  endtask

  task automatic t_trap();
    cur_lvl = 2'd3;
    tick(); trap_req = 1'b1;
    tick(); trap_req = 1'b0; #1;
    check("R10 wake after trap", wake, 1);
    check("R2 trap vector at level 3", irq_vector, 1);
    check("R2 trap new level", irq_new_lvl, 3);
    accept();
    check("R10 wake drops after take", wake, 0);
    check("R2 trap taken", irq_valid, 0);
  endtask

  task automatic t_order();
    cur_lvl = 2'd0; set_prio(0, 3); src_en[0] = 1'b1;
    tick(); trap_req = 1'b1; nmi_req = 1'b1; src_flag[0] = 1'b1;
    tick(); trap_req = 1'b0; nmi_req = 1'b0; src_flag[0] = 1'b0; #1;
    check("R3 trap ranks first", irq_vector, 1);
    accept();
    check("R3 non-maskable next", irq_vector, 2);
    check("R3 non-maskable new level", irq_new_lvl, 3);
    check("R10 wake while nm pending", wake, 1);
    accept();
    check("R3 maskable last", irq_vector, 3);
    accept();
    check("R3 drained", irq_valid, 0);
    src_en = '0;
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_mask_basic();
    t_strict();
    t_enable();
    t_gate();
    t_clear();
    t_tie();
    t_trap();
    t_order();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule